// File: doc/BRIEF.md
# Processor Control Register Bank

This block keeps three dedicated control words of a 32-bit processor core: the base address of the exception vector table, the link word that holds a subroutine's return address, and the privileged (system) stack pointer. A fourth word, the unprivileged stack pointer, lives beside them so that general register 15 can be steered to one stack or the other by a single stack-select flag from the core's status word.

The core drives plain strobes: a call strobe with the current program counter loads the link word, a return strobe makes the link word appear as the next program counter, and an exception-entry strobe starts a two-cycle push sequence. That sequence lowers the system stack pointer by one word per cycle and hands out the address for the saved status word first and the saved program counter second. Dedicated write ports reach the vector base, the link word and the system stack pointer directly. Decode, memory traffic and vector fetch belong to other blocks.

Top module: `dreg_bank`

## Requirements
- R1: After reset the vector base output `tb_q` reads 0x000FFC00, `ssp_q` reads 0, the unprivileged stack pointer reads 0 (seen on `r15_rdata` with `stack_sel`=1), and `push_vld` and `ret_vld` are 0.
- R2: When `tb_we` is 1 at a rising edge, `tb_q` holds `tb_wdata` from the next cycle on; without `tb_we` it does not change.
- R3: When `call_stb` is 1 at a rising edge, `call_pc` is copied into the link word, visible on `rp_q` in the next cycle.
- R4: `rp_we` loads `rp_wdata` into the link word; when `call_stb` and `rp_we` are both 1 in the same cycle, the link word takes `call_pc`.
- R5: In the cycle after `ret_stb` is 1, `ret_vld` is 1 for exactly one cycle and `ret_pc` equals the link word as it stood when the strobe was sampled.
- R6: With `stack_sel`=0, `r15_rdata` shows the system stack pointer in the same cycle, and `r15_we` writes `r15_wdata` into it.
- R7: With `stack_sel`=1, `r15_rdata` shows the unprivileged stack pointer and `r15_we` writes only that register; the system stack pointer is unchanged.
- R8: `ssp_we` writes `ssp_wdata` into the system stack pointer; when it coincides with a register-15 write that targets the same register, `ssp_wdata` wins.
- R9: After an `exc_stb` accepted in cycle N, cycle N+1 shows `push_vld`=1, `push_is_pc`=0 with `push_addr` = old pointer − 4, and cycle N+2 shows `push_vld`=1, `push_is_pc`=1 with `push_addr` = old pointer − 8; arithmetic wraps modulo 2^32.
- R10: At the end of the sequence `ssp_q` equals old pointer − 8; any system stack pointer write (direct or through register 15) in cycle N or N+1 is dropped.
- R11: An `exc_stb` arriving in cycle N+1, while the first push is shown, is ignored: no third push occurs and the pointer ends 8 lower, not 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stack_sel | input | 1 | Stack-select flag: 0 routes register 15 to the system stack pointer, 1 to the unprivileged one |
| tb_we | input | 1 | Vector base write enable |
| tb_wdata | input | 32 | Vector base write data |
| tb_q | output | 32 | Vector table base address |
| rp_we | input | 1 | Link word write enable |
| rp_wdata | input | 32 | Link word write data |
| rp_q | output | 32 | Link word value |
| call_stb | input | 1 | Subroutine call strobe |
| call_pc | input | 32 | Program counter to save on call |
| ret_stb | input | 1 | Subroutine return strobe |
| ret_vld | output | 1 | Return target valid, one cycle |
| ret_pc | output | 32 | Return target program counter |
| ssp_we | input | 1 | System stack pointer write enable |
| ssp_wdata | input | 32 | System stack pointer write data |
| ssp_q | output | 32 | System stack pointer value |
| r15_we | input | 1 | General register 15 write enable |
| r15_wdata | input | 32 | General register 15 write data |
| r15_rdata | output | 32 | General register 15 read value |
| exc_stb | input | 1 | Exception entry strobe |
| push_vld | output | 1 | Push address valid |
| push_is_pc | output | 1 | 0: status word slot, 1: program counter slot |
| push_addr | output | 32 | Word address of the current push |

## Verification
Two pairs of functions collide here: a call and a direct link-word write landing in the same cycle, and an exception entry landing together with writes to the system stack pointer. The bench raises `call_stb` and `rp_we` with different data on the same edge and expects the call's program counter on `rp_q`. It also raises `exc_stb` together with `ssp_we`, then repeats both during the first push cycle, and judges by the two push addresses and the final pointer, which must show only the two decrements.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned WORD_BYTE = WORD_W / 8;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_SECOND = 1'b1
  } push_phase_e;
endpackage

// File: rtl/dreg_word.sv
module dreg_word #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= d;
  end
endmodule

// File: rtl/dreg_link.sv
module dreg_link #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         call_stb,
  input  logic [W-1:0] call_pc,
  input  logic         ret_stb,
  output logic [W-1:0] link_q,
  output logic         ret_vld,
  output logic [W-1:0] ret_pc
);
  // Link word carries no reset value: software or a call must set it first.
  always_ff @(posedge clk) begin
    if (call_stb)  link_q <= call_pc;
    else if (we)   link_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_vld <= 1'b0;
      ret_pc  <= '0;
    end else begin
      ret_vld <= ret_stb;
      if (ret_stb) ret_pc <= link_q;
    end
  end
endmodule

// File: rtl/dreg_stack.sv
module dreg_stack
  import dreg_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned STEP = 4,
  parameter logic [W-1:0] SSP_RST = '0,
  parameter logic [W-1:0] USP_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stack_sel,
  input  logic         ssp_we,
  input  logic [W-1:0] ssp_wdata,
  input  logic         r15_we,
  input  logic [W-1:0] r15_wdata,
  input  logic         exc_stb,
  output logic [W-1:0] ssp_q,
  output logic [W-1:0] usp_q,
  output logic         push_vld,
  output logic         push_is_pc,
  output logic [W-1:0] push_addr
);
  localparam logic [W-1:0] STEP_W = W'(STEP);

  push_phase_e phase;
  logic [W-1:0] ssp_dec;

  assign ssp_dec = ssp_q - STEP_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ssp_q      <= SSP_RST;
      phase      <= PH_IDLE;
      push_vld   <= 1'b0;
      push_is_pc <= 1'b0;
      push_addr  <= '0;
    end else begin
      push_vld   <= 1'b0;
      push_is_pc <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (exc_stb) begin
            ssp_q     <= ssp_dec;
            push_addr <= ssp_dec;
            push_vld  <= 1'b1;
            phase     <= PH_SECOND;
          end else if (ssp_we) begin
            ssp_q <= ssp_wdata;
          end else if (r15_we && !stack_sel) begin
            ssp_q <= r15_wdata;
          end
        end
        default: begin
          ssp_q      <= ssp_dec;
          push_addr  <= ssp_dec;
          push_vld   <= 1'b1;
          push_is_pc <= 1'b1;
          phase      <= PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       usp_q <= USP_RST;
    else if (r15_we && stack_sel)  usp_q <= r15_wdata;
  end
endmodule

// File: rtl/dreg_bank.sv
module dreg_bank
  import dreg_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter logic [W-1:0] TB_RST = 32'h000F_FC00,
  parameter logic [W-1:0] SSP_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stack_sel,
  input  logic         tb_we,
  input  logic [W-1:0] tb_wdata,
  output logic [W-1:0] tb_q,
  input  logic         rp_we,
  input  logic [W-1:0] rp_wdata,
  output logic [W-1:0] rp_q,
  input  logic         call_stb,
  input  logic [W-1:0] call_pc,
  input  logic         ret_stb,
  output logic         ret_vld,
  output logic [W-1:0] ret_pc,
  input  logic         ssp_we,
  input  logic [W-1:0] ssp_wdata,
  output logic [W-1:0] ssp_q,
  input  logic         r15_we,
  input  logic [W-1:0] r15_wdata,
  output logic [W-1:0] r15_rdata,
  input  logic         exc_stb,
  output logic         push_vld,
  output logic         push_is_pc,
  output logic [W-1:0] push_addr
);
  logic [W-1:0] usp_q;

  dreg_word #(.W(W), .RST_VAL(TB_RST)) i_tbase (
    .clk(clk), .rst(rst), .we(tb_we), .d(tb_wdata), .q(tb_q)
  );

  dreg_link #(.W(W)) i_link (
    .clk(clk), .rst(rst), .we(rp_we), .wdata(rp_wdata),
    .call_stb(call_stb), .call_pc(call_pc), .ret_stb(ret_stb),
    .link_q(rp_q), .ret_vld(ret_vld), .ret_pc(ret_pc)
  );

  dreg_stack #(.W(W), .STEP(W / 8), .SSP_RST(SSP_RST), .USP_RST('0)) i_stack (
    .clk(clk), .rst(rst), .stack_sel(stack_sel),
    .ssp_we(ssp_we), .ssp_wdata(ssp_wdata),
    .r15_we(r15_we), .r15_wdata(r15_wdata), .exc_stb(exc_stb),
    .ssp_q(ssp_q), .usp_q(usp_q),
    .push_vld(push_vld), .push_is_pc(push_is_pc), .push_addr(push_addr)
  );

  assign r15_rdata = stack_sel ? usp_q : ssp_q;
endmodule

// File: rtl/dreg_bank_chk.sv
module dreg_bank_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         stack_sel,
  input logic         tb_we,
  input logic [W-1:0] tb_q,
  input logic [W-1:0] rp_q,
  input logic         call_stb,
  input logic [W-1:0] call_pc,
  input logic         ret_stb,
  input logic         ret_vld,
  input logic [W-1:0] ret_pc,
  input logic         ssp_we,
  input logic [W-1:0] ssp_q,
  input logic         r15_we,
  input logic         exc_stb,
  input logic         push_vld,
  input logic         push_is_pc,
  input logic [W-1:0] push_addr
);
  localparam logic [W-1:0] STEP_W = W'(W / 8);

  AST_TB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tb_we |=> $stable(tb_q)); // R2

  AST_CALL_WINS: assert property (@(posedge clk) disable iff (rst)
    call_stb |=> rp_q == $past(call_pc)); // R4

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
    ret_stb |=> ret_vld && ret_pc == $past(rp_q)); // R5

  AST_RET_PULSE: assert property (@(posedge clk) disable iff (rst)
    !ret_stb |=> !ret_vld); // R5

  AST_SSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ssp_we && !(r15_we && !stack_sel) && !exc_stb && !(push_vld && !push_is_pc))
      |=> $stable(ssp_q)); // R7

  AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (rst)
    (push_vld && !push_is_pc) |=> (push_vld && push_is_pc)); // R9

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (push_vld && !push_is_pc) |=> push_addr == $past(push_addr) - STEP_W); // R9

  AST_PUSH_END: assert property (@(posedge clk) disable iff (rst)
    (push_vld && push_is_pc) |-> ssp_q == push_addr); // R10

  AST_NO_THIRD: assert property (@(posedge clk) disable iff (rst)
    (push_vld && push_is_pc) |=> !(push_vld && push_is_pc)); // R11
endmodule

bind dreg_bank dreg_bank_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .stack_sel(stack_sel), .tb_we(tb_we), .tb_q(tb_q),
  .rp_q(rp_q), .call_stb(call_stb), .call_pc(call_pc), .ret_stb(ret_stb),
  .ret_vld(ret_vld), .ret_pc(ret_pc), .ssp_we(ssp_we), .ssp_q(ssp_q),
  .r15_we(r15_we), .exc_stb(exc_stb), .push_vld(push_vld),
  .push_is_pc(push_is_pc), .push_addr(push_addr)
);

// File: tb/test_dreg_bank.sv
module test_dreg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stack_sel = 1'b0;
  logic        tb_we = 1'b0;
  logic [31:0] tb_wdata = '0;
  logic [31:0] tb_q;
  logic        rp_we = 1'b0;
  logic [31:0] rp_wdata = '0;
  logic [31:0] rp_q;
  logic        call_stb = 1'b0;
  logic [31:0] call_pc = '0;
  logic        ret_stb = 1'b0;
  logic        ret_vld;
  logic [31:0] ret_pc;
  logic        ssp_we = 1'b0;
  logic [31:0] ssp_wdata = '0;
  logic [31:0] ssp_q;
  logic        r15_we = 1'b0;
  logic [31:0] r15_wdata = '0;
  logic [31:0] r15_rdata;
  logic        exc_stb = 1'b0;
  logic        push_vld;
  logic        push_is_pc;
  logic [31:0] push_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dreg_bank i_dreg_bank (
    .clk(clk), .rst(rst), .stack_sel(stack_sel),
    .tb_we(tb_we), .tb_wdata(tb_wdata), .tb_q(tb_q),
    .rp_we(rp_we), .rp_wdata(rp_wdata), .rp_q(rp_q),
    .call_stb(call_stb), .call_pc(call_pc), .ret_stb(ret_stb),
    .ret_vld(ret_vld), .ret_pc(ret_pc),
    .ssp_we(ssp_we), .ssp_wdata(ssp_wdata), .ssp_q(ssp_q),
    .r15_we(r15_we), .r15_wdata(r15_wdata), .r15_rdata(r15_rdata),
    .exc_stb(exc_stb), .push_vld(push_vld), .push_is_pc(push_is_pc),
    .push_addr(push_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    tb_we = 0; rp_we = 0; call_stb = 0; ret_stb = 0;
    ssp_we = 0; r15_we = 0; exc_stb = 0;
  endtask

  task automatic t_reset();
    stack_sel = 1'b1;
    #1;
    chk("R1 tb_q", tb_q, 32'h000F_FC00);
    chk("R1 ssp_q", ssp_q, 32'h0);
    chk("R1 usp via r15", r15_rdata, 32'h0);
    chk("R1 push_vld", {31'b0, push_vld}, 32'h0);
    chk("R1 ret_vld", {31'b0, ret_vld}, 32'h0);
    stack_sel = 1'b0;
  endtask

  task automatic t_tbase();
    tb_we = 1; tb_wdata = 32'h1234_5678;
    step(); idle_inputs();
    chk("R2 tb write", tb_q, 32'h1234_5678);
    tb_wdata = 32'hDEAD_BEEF;
    step();
    chk("R2 tb hold", tb_q, 32'h1234_5678);
  endtask

  task automatic t_call_ret();
    rp_we = 1; rp_wdata = 32'hAAAA_0000;
    step(); idle_inputs();
    chk("R4 rp write", rp_q, 32'hAAAA_0000);
    ret_stb = 1;
    step(); idle_inputs();
    chk("R5 ret_vld", {31'b0, ret_vld}, 32'h1);
    chk("R5 ret_pc", ret_pc, 32'hAAAA_0000);
    call_stb = 1; call_pc = 32'h0000_1000;
    step(); idle_inputs();
    chk("R5 ret_vld single", {31'b0, ret_vld}, 32'h0);
    chk("R3 call loads", rp_q, 32'h0000_1000);
    ret_stb = 1;
    step(); idle_inputs();
    chk("R5 ret after call", ret_pc, 32'h0000_1000);
  endtask

  task automatic t_call_collide();
    rp_we = 1; rp_wdata = 32'h5555_5555;
    call_stb = 1; call_pc = 32'h2222_2222;
    step(); idle_inputs();
    chk("R4 call wins", rp_q, 32'h2222_2222);
  endtask

  task automatic t_r15();
    stack_sel = 0; r15_we = 1; r15_wdata = 32'h0000_8000;
    step(); idle_inputs();
    chk("R6 ssp via r15", ssp_q, 32'h0000_8000);
    chk("R6 r15 read", r15_rdata, 32'h0000_8000);
    stack_sel = 1; r15_we = 1; r15_wdata = 32'h0000_4000;
    step(); idle_inputs();
    chk("R7 ssp untouched", ssp_q, 32'h0000_8000);
    chk("R7 usp read", r15_rdata, 32'h0000_4000);
    stack_sel = 0; #1;
    chk("R6 read follows flag", r15_rdata, 32'h0000_8000);
  endtask

  task automatic t_ssp_prio();
    stack_sel = 0;
    ssp_we = 1; ssp_wdata = 32'h0000_9000;
    r15_we = 1; r15_wdata = 32'h0000_1111;
    step(); idle_inputs();
    chk("R8 direct wins", ssp_q, 32'h0000_9000);
  endtask

  task automatic t_exc(input logic [31:0] base, input bit disturb);
    ssp_we = 1; ssp_wdata = base;
    step(); idle_inputs();
    exc_stb = 1;
    if (disturb) begin ssp_we = 1; ssp_wdata = 32'h7777_7777; end
    step(); idle_inputs();
    chk("R9 first vld", {31'b0, push_vld}, 32'h1);
    chk("R9 first is status", {31'b0, push_is_pc}, 32'h0);
    chk("R9 first addr", push_addr, base - 32'd4);
    if (disturb) begin
      exc_stb = 1; ssp_we = 1; ssp_wdata = 32'h3333_3333;
      stack_sel = 0; r15_we = 1; r15_wdata = 32'h4444_4444;
    end
    step(); idle_inputs();
    chk("R9 second vld", {31'b0, push_vld}, 32'h1);
    chk("R9 second is pc", {31'b0, push_is_pc}, 32'h1);
    chk("R9 second addr", push_addr, base - 32'd8);
    chk("R10 ptr at end", ssp_q, base - 32'd8);
    step();
    chk("R11 no third push", {31'b0, push_vld}, 32'h0);
    chk("R11 ptr final", ssp_q, base - 32'd8);
  endtask

  initial begin
    idle_inputs();
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_tbase();
    t_call_ret();
    t_call_collide();
    t_r15();
    t_ssp_prio();
    t_exc(32'h0000_9000, 1'b0);
    t_exc(32'h0000_9000, 1'b1);
    t_exc(32'h0000_0000, 1'b0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule